// File: doc/BRIEF.md
# S/PDIF Audio Transmitter with Channel-Status and User-Message Insertion

This block turns a stream of 20-bit stereo PCM samples into a serial S/PDIF line signal. Each frame carries a left and a right subframe. Every subframe holds a synchronisation preamble, four zero auxiliary bits, the 20 sample bits, a validity flag, a user-data bit, a channel-status bit and an even-parity bit. The line is biphase-mark coded, and one clock cycle equals one half-cell. The clock therefore runs at 128 times the sample rate. Samples enter through a valid/ready handshake into a one-deep holding register. Each frame takes the held sample when the previous frame ends.

A byte-wide write port fills two stores. The first is five channel-status bytes, which are sent during the first forty frames of every 192-frame block. The rest of the block is zero. The second is a 129-byte user message. A message-start strobe makes the block stream the message at two bits per frame, then return to zero user bits. A mute input replaces the audio with silence flagged as invalid, and framing carries on unchanged.

Top module: `spdif_tx`

## Requirements
- R1: Frames are numbered 0 to 191 and then wrap. Subframe 0 of frame 0 starts with preamble B (half-cells 11101000). Other left subframes start with M (11100010), and right subframes start with W (11100100). These patterns apply when the line was low before the preamble. When the line was high, each pattern is inverted.
- R2: Every data slot 4 to 31 starts with a level change. A slot carries a second change in its middle if and only if its bit is 1.
- R3: A sample accepted with `smp_valid && smp_ready` during frame k is sent in frame k+1. Slots 8 to 27 carry the sample, LSB first. Slots 4 to 7 are zero, and the validity bit in slot 28 is 0.
- R4: If no sample is held when a frame ends, the next frame sends zero samples with validity 1.
- R5: If `mute` is high when a frame ends, the next frame sends zero samples with validity 1, and the held sample is dropped.
- R6: Slot 31 makes the count of ones across slots 4 to 31 even.
- R7: The channel-status bit in slot 30 is the same in both subframes. For frame f below 40 it is bit f%8 of status byte f/8, otherwise 0. A write with `cfg_sel`=0 to addresses 0 to 4 sets a status byte. A write to any other address has no effect.
- R8: Writes with `cfg_sel`=1 to addresses 0 to 128 fill the message. After a `msg_go` pulse the message starts at the next frame. Byte j is sent over four frames, LSB first, with left taking the even bits and right the odd bits, for 516 frames in total.
- R9: The user bit in slot 29 is 0 before any `msg_go` and after the whole message has been sent.
- R10: A new `msg_go` restarts the message from byte 0 at the next frame.
- R11: During reset `tx_out` is low and `smp_ready` is high. The first frame after reset is frame 0.
- R12: `smp_ready` is high exactly when the holding register is empty. After a sample is accepted it stays low until the current frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, 128 x sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Holding register empty |
| smp_left | input | 20 | Left PCM sample |
| smp_right | input | 20 | Right PCM sample |
| mute | input | 1 | Silence the next frame |
| cfg_we | input | 1 | Write strobe |
| cfg_sel | input | 1 | 0 = status bytes, 1 = message buffer |
| cfg_addr | input | 8 | Byte address |
| cfg_wdata | input | 8 | Byte to write |
| msg_go | input | 1 | Start (or restart) the user message |
| tx_out | output | 1 | Biphase-mark line output |

## Verification
The assertions check several properties on every cycle:
- a level change at the start of each data cell;
- the repeated level inside every preamble;
- the return of the line to its pre-data level at each subframe end, which follows from even parity;
- the handshake dropping ready after an accept;
- the frame counter wrapping at 191.

Other behaviour shows up only in the bench's decoded stream: sample placement, the mute and underrun substitution, the status bit for each frame, ignored out-of-range status writes, and the user message's start, end and restart.

// File: rtl/spdif_tx.sv
module spdif_tx #(
  parameter int CS_BYTES   = 5,
  parameter int MSG_BYTES  = 129,
  parameter int BLK_FRAMES = 192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  output logic        smp_ready,
  input  logic [19:0] smp_left,
  input  logic [19:0] smp_right,
  input  logic        mute,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  input  logic        msg_go,
  output logic        tx_out
);
  localparam int FW = $clog2(BLK_FRAMES);
  localparam int MW = $clog2(MSG_BYTES);
  localparam int CW = $clog2(CS_BYTES);
  localparam logic [FW-1:0] FR_LAST = FW'(BLK_FRAMES - 1);
  localparam logic [FW-1:0] CS_BITS = FW'(CS_BYTES * 8);
  localparam logic [MW-1:0] MB_LAST = MW'(MSG_BYTES - 1);
  localparam logic [7:0]    CS_TOP  = 8'(CS_BYTES - 1);
  localparam logic [7:0]    MSG_TOP = 8'(MSG_BYTES - 1);

  logic [6:0]    hc;
  logic [FW-1:0] fr;
  logic [19:0]   hold_l, hold_r, cur_l, cur_r;
  logic          hold_full, cur_v;
  logic [7:0]    cs  [CS_BYTES];
  logic [7:0]    msg [MSG_BYTES];
  logic          msg_pend, msg_act;
  logic [MW-1:0] mbyte;
  logic [1:0]    mpair;
  logic          tx_q, pbase, par, bitv, cbit, tx_d;

  wire       frame_end = (hc == 7'd127);
  wire       sub       = hc[6];
  wire [4:0] slot      = hc[5:1];
  wire       take      = smp_valid && smp_ready;
  wire [19:0] cur      = sub ? cur_r : cur_l;
  wire [7:0] mb        = msg[mbyte];
  wire       ubit      = msg_act & mb[{mpair, sub}];
  wire [7:0] pat       = sub ? 8'b11100100 : ((fr == '0) ? 8'b11101000 : 8'b11100010);

  assign smp_ready = !hold_full;
  assign tx_out    = tx_q;

  always_comb begin
    cbit = 1'b0;
    if (fr < CS_BITS) cbit = cs[fr[3 +: CW]][fr[2:0]];
  end

  always_comb begin
    bitv = 1'b0;
    if (slot >= 5'd8 && slot <= 5'd27) bitv = cur[slot - 5'd8];
    else if (slot == 5'd28) bitv = cur_v;
    else if (slot == 5'd29) bitv = ubit;
    else if (slot == 5'd30) bitv = cbit;
    else if (slot == 5'd31) bitv = par;
  end

  always_comb begin
    if (slot < 5'd4) tx_d = pat[3'd7 - hc[2:0]] ^ ((hc[2:0] == 3'd0) ? tx_q : pbase);
    else             tx_d = hc[0] ? (tx_q ^ bitv) : ~tx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc <= '0; fr <= '0; tx_q <= 1'b0; pbase <= 1'b0; par <= 1'b0;
      hold_full <= 1'b0; hold_l <= '0; hold_r <= '0;
      cur_l <= '0; cur_r <= '0; cur_v <= 1'b1;
    end else begin
      hc   <= hc + 7'd1;
      tx_q <= tx_d;
      if (hc[5:0] == 6'd0) pbase <= tx_q;
      if (hc[5:0] == 6'd0) par <= 1'b0;
      else if (hc[0] && slot >= 5'd4 && slot <= 5'd30 && bitv) par <= ~par;
      if (frame_end) begin
        fr <= (fr == FR_LAST) ? '0 : fr + 1'b1;
        if (hold_full && !mute) begin
          cur_l <= hold_l; cur_r <= hold_r; cur_v <= 1'b0;
        end else begin
          cur_l <= '0; cur_r <= '0; cur_v <= 1'b1;
        end
        hold_full <= 1'b0;
      end
      if (take) begin
        hold_l <= smp_left; hold_r <= smp_right; hold_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_pend <= 1'b0; msg_act <= 1'b0; mbyte <= '0; mpair <= '0;
    end else begin
      if (frame_end) begin
        if (msg_pend) begin
          msg_act <= 1'b1; mbyte <= '0; mpair <= '0; msg_pend <= 1'b0;
        end else if (msg_act) begin
          mpair <= mpair + 2'd1;
          if (mpair == 2'd3) begin
            if (mbyte == MB_LAST) msg_act <= 1'b0;
            else mbyte <= mbyte + 1'b1;
          end
        end
      end
      if (msg_go) msg_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CS_BYTES; i++) cs[i] <= '0;
    end else if (cfg_we && !cfg_sel && cfg_addr <= CS_TOP) begin
      cs[cfg_addr[CW-1:0]] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_sel && cfg_addr <= MSG_TOP) msg[cfg_addr[MW-1:0]] <= cfg_wdata;
  end
endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_out,
  input logic       smp_valid,
  input logic       smp_ready,
  input logic [6:0] hc,
  input logic [7:0] fr
);
  logic lvl_ref, lvl_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_ok  <= 1'b0;
      lvl_ref <= 1'b0;
    end else if (hc[5:0] == 6'd8) begin
      lvl_ref <= tx_out;
      lvl_ok  <= 1'b1;
    end
  end

  a_r2_cell_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (hc[0] && hc[5:1] >= 5'd4) |-> tx_out != $past(tx_out));

  a_r1_preamble_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hc[5:0] == 6'd3) |-> tx_out == $past(tx_out));

  a_r6_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_ok && hc[5:0] == 6'd0) |-> tx_out == lvl_ref);

  a_r12_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  a_r1_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hc == 7'd127 && fr == 8'd191) |=> fr == 8'd0);
endmodule

bind spdif_tx spdif_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_out(tx_out), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .hc(hc), .fr(fr)
);

// File: tb/spdif_tx_tb_top.sv
module spdif_tx_tb_top;
  localparam int NFR = 600;
  localparam logic [7:0] PB = 8'b11101000;
  localparam logic [7:0] PM = 8'b11100010;
  localparam logic [7:0] PW = 8'b11100100;
  localparam logic [40:0] VEC [8] = '{
    {1'b0, 20'h12345, 20'hABCDE},
    {1'b0, 20'hFFFFF, 20'h00000},
    {1'b1, 20'h55555, 20'hAAAAA},
    {1'b0, 20'h80000, 20'h00001},
    {1'b0, 20'h0F0F0, 20'hF0F0F},
    {1'b1, 20'hFFFFF, 20'hFFFFF},
    {1'b0, 20'h00001, 20'h80000},
    {1'b0, 20'h7FFFF, 20'h3C3C3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_ready, mute = 1'b0;
  logic [19:0] smp_left = '0, smp_right = '0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, msg_go = 1'b0, tx_out;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0;
  int n_chk = 0, n_err = 0, cur_k = -1, cur_s = 0;

  always #4 clk = ~clk;

  spdif_tx dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .mute(mute),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .msg_go(msg_go), .tx_out(tx_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s frame %0d sub %0d: actual %0h expected %0h", req, cur_k, cur_s, act, exp);
    end
  endtask

  function automatic logic [7:0] msg_byte(input int j);
    return 8'((j * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] cs_byte(input int j);
    case (j)
      0: return 8'hA5;
      1: return 8'h3C;
      2: return 8'h81;
      3: return 8'h0F;
      default: return 8'h66;
    endcase
  endfunction

  task automatic write_cfg(input logic sel, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic producer();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      while (!smp_ready) @(negedge clk);
      smp_valid = 1'b1; mute = VEC[i][40];
      smp_left = VEC[i][39:20]; smp_right = VEC[i][19:0];
      @(negedge clk);
      smp_valid = 1'b0;
      check("R12", smp_ready, 1'b0);
    end
  endtask

  task automatic config_run();
    for (int j = 0; j < 5; j++) write_cfg(1'b0, 8'(j), cs_byte(j));
    write_cfg(1'b0, 8'd5, 8'hFF);
    @(negedge clk); msg_go = 1'b1;
    @(negedge clk); msg_go = 1'b0;
    repeat (560 * 128) @(negedge clk);
    msg_go = 1'b1;
    @(negedge clk); msg_go = 1'b0;
  endtask

  task automatic decoder();
    logic lv = 1'b0;
    for (int k = 0; k < NFR; k++) begin
      for (int s = 0; s < 2; s++) begin
        logic [63:0] hv;
        logic [31:0] bits;
        logic [7:0]  pat, got;
        logic [19:0] es;
        logic        ev, eu, ec;
        int          miss, m, f;
        string       tag;
        cur_k = k; cur_s = s;
        for (int i = 0; i < 64; i++) begin @(negedge clk); hv[i] = tx_out; end
        pat = (s == 1) ? PW : (((k % 192) == 0) ? PB : PM);
        for (int i = 0; i < 8; i++) got[7 - i] = hv[i] ^ lv;
        check("R1", got, pat);
        miss = 0; bits = '0;
        for (int b = 4; b < 32; b++) begin
          bits[b] = hv[2*b] ^ hv[2*b+1];
          if (hv[2*b] == hv[2*b-1]) miss++;
        end
        check("R2", 64'(miss), 64'd0);
        if (k >= 1 && k <= 8) begin
          ev  = VEC[k-1][40];
          es  = ev ? 20'h0 : ((s == 1) ? VEC[k-1][19:0] : VEC[k-1][39:20]);
          tag = ev ? "R5" : "R3";
        end else begin
          ev = 1'b1; es = '0; tag = "R4";
        end
        check(tag, bits[27:4], {es, 4'h0});
        check(tag, bits[28], ev);
        m = -1; tag = "R9";
        if (k >= 1 && k <= 516) begin m = k - 1; tag = "R8"; end
        else if (k >= 561) begin m = k - 561; tag = "R10"; end
        eu = (m < 0) ? 1'b0 : msg_byte(m / 4)[2 * (m % 4) + s];
        check(tag, bits[29], eu);
        f  = k % 192;
        ec = (f < 40) ? cs_byte(f / 8)[f % 8] : 1'b0;
        check("R7", bits[30], ec);
        check("R6", 64'(^bits[31:4]), 64'd0);
        lv = hv[63];
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int j = 0; j < 129; j++) write_cfg(1'b1, 8'(j), msg_byte(j));
    @(negedge clk);
    check("R11", tx_out, 1'b0);
    check("R11", smp_ready, 1'b1);
    rst_n = 1'b1;
    fork
      producer();
      config_run();
      decoder();
    join
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule